// File: doc/BRIEF.md
# Aliased Set/Clear/Toggle Control Register Bank

A bank of control registers behind a simple synchronous memory-mapped port. Every register occupies a 16-byte window. The window holds four word addresses, and each of them updates the same storage in a different bitwise way. One alias stores the write data as it is. The other three change only the bits where the write data holds a one: they set those bits, clear them or invert them. Software can therefore change single control bits in one bus write, with no read-modify-write sequence and no race against other writers of the same register.

Reads are accepted on any of the four aliases and all return the stored value. Read data is registered, so it appears one cycle after the read request. The full contents of every register also drive a flat parallel output, which feeds the logic the bank controls. Writes take effect on the clock edge that samples them. Addresses that fall past the last register window are ignored on writes and read as zero.

Top module: `alias_reg_bank`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears every register and the read data to zero.
- R2: A write whose address bits [3:2] equal 0 replaces the selected register with the write data.
- R3: A write whose address bits [3:2] equal 1 sets every register bit where the write data is 1 and keeps the other bits.
- R4: A write whose address bits [3:2] equal 2 clears every register bit where the write data is 1 and keeps the other bits.
- R5: A write whose address bits [3:2] equal 3 inverts every register bit where the write data is 1 and keeps the other bits.
- R6: A read (rd_en high at an edge) from any of the four aliases of a register loads that register's value into rd_data at that edge; rd_data holds its value while rd_en is low.
- R7: A write takes effect at the edge that samples it and shows on regs_flat after that edge; a read sampled at the same edge returns the value from before the write.
- R8: Address bits [ADDR_W-1:4] select the register, and register n sits at slice [n*DATA_W +: DATA_W] of regs_flat; when that field is NUM_REGS or larger, a write changes no register and a read returns zero.
- R9: Address bits [1:0] have no effect on which register or mode is selected.
- R10: While wr_en is low, no register changes, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Byte address: [3:2] access mode, [ADDR_W-1:4] register number |
| wr_en | input | 1 | Write request for this cycle |
| wr_data | input | DATA_W | Write data or bit mask |
| rd_en | input | 1 | Read request for this cycle |
| rd_data | output | DATA_W | Registered read data |
| regs_flat | output | NUM_REGS*DATA_W | Current value of every register, register 0 in the low slice |

## Verification
Every register is visible on regs_flat, so a bit that one of the alias updates computes wrongly shows up at the ports on the edge that applies the write. A neighbouring register that a mis-decoded address touches shows up on the same edge. A wrong mode decode is usually the same as a different mode, so each pattern is written onto a register that already holds a mix of ones and zeros, where the four updates give four different results. Faults in the read path appear one cycle after the read request, and the bench compares rd_data there against its own model.

// File: rtl/alias_bank_pkg.sv
package alias_bank_pkg;

  // Access mode carried in address bits [3:2].
  typedef enum logic [1:0] {
    MODE_STORE  = 2'd0,
    MODE_SET    = 2'd1,
    MODE_CLEAR  = 2'd2,
    MODE_INVERT = 2'd3
  } access_mode_e;

  // Byte span of one register window (four word aliases).
  localparam int WINDOW_SHIFT = 4;

  // Width of a register index for a bank of n registers.
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/alias_addr_decode.sv
module alias_addr_decode
  import alias_bank_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 8,
  parameter int IDX_W    = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  reg_idx,
  output access_mode_e      acc_mode,
  output logic              in_range
);
  localparam int SEL_W = ADDR_W - WINDOW_SHIFT;

  logic [SEL_W-1:0] reg_num;
  logic             byte_lane_unused;

  assign reg_num          = addr[ADDR_W-1:WINDOW_SHIFT];
  assign reg_idx          = reg_num[IDX_W-1:0];
  assign acc_mode         = access_mode_e'(addr[3:2]);
  assign byte_lane_unused = ^addr[1:0];

  always_comb begin
    in_range = (int'(reg_num) < NUM_REGS);
  end

endmodule

// File: rtl/alias_reg_cell.sv
module alias_reg_cell
  import alias_bank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  access_mode_e      mode,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);

  // Bitwise update applied by each alias.
  function automatic logic [DATA_W-1:0] next_value(
    input logic [DATA_W-1:0] cur,
    input logic [DATA_W-1:0] mask,
    input access_mode_e      m
  );
    logic [DATA_W-1:0] res;
    unique case (m)
      MODE_STORE:  res = mask;
      MODE_SET:    res = cur | mask;
      MODE_CLEAR:  res = cur & ~mask;
      MODE_INVERT: res = cur ^ mask;
      default:     res = cur;
    endcase
    return res;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (hit) begin
      q <= next_value(q, wdata, mode);
    end
  end

endmodule

// File: rtl/alias_read_port.sv
module alias_read_port #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  parameter int IDX_W    = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rd_en,
  input  logic [IDX_W-1:0]           reg_idx,
  input  logic                       in_range,
  input  logic [NUM_REGS*DATA_W-1:0] regs_flat,
  output logic [DATA_W-1:0]          rd_data
);
  logic [DATA_W-1:0] sel_value;

  always_comb begin
    if (in_range) begin
      sel_value = regs_flat[reg_idx*DATA_W +: DATA_W];
    end else begin
      sel_value = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= sel_value;
    end
  end

endmodule

// File: rtl/alias_reg_bank.sv
module alias_reg_bank
  import alias_bank_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       wr_en,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       rd_en,
  output logic [DATA_W-1:0]          rd_data,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
  localparam int IDX_W = idx_width(NUM_REGS);

  // Named internal events, also observed by the bound checker.
  logic [IDX_W-1:0]    reg_idx;
  access_mode_e        acc_mode;
  logic                addr_in_range;
  logic [NUM_REGS-1:0] wr_hit;

  alias_addr_decode #(
    .ADDR_W  (ADDR_W),
    .NUM_REGS(NUM_REGS),
    .IDX_W   (IDX_W)
  ) u_decode (
    .addr    (addr),
    .reg_idx (reg_idx),
    .acc_mode(acc_mode),
    .in_range(addr_in_range)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    assign wr_hit[g] = wr_en && addr_in_range && (reg_idx == IDX_W'(g));

    alias_reg_cell #(
      .DATA_W(DATA_W)
    ) u_cell (
      .clk  (clk),
      .rst  (rst),
      .hit  (wr_hit[g]),
      .mode (acc_mode),
      .wdata(wr_data),
      .q    (regs_flat[g*DATA_W +: DATA_W])
    );
  end

  alias_read_port #(
    .DATA_W  (DATA_W),
    .NUM_REGS(NUM_REGS),
    .IDX_W   (IDX_W)
  ) u_read (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .reg_idx  (reg_idx),
    .in_range (addr_in_range),
    .regs_flat(regs_flat),
    .rd_data  (rd_data)
  );

endmodule

// File: rtl/alias_reg_bank_chk.sv
module alias_reg_bank_chk #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  parameter int IDX_W    = 3
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       wr_en,
  input logic [DATA_W-1:0]          wr_data,
  input logic                       rd_en,
  input logic [DATA_W-1:0]          rd_data,
  input logic [NUM_REGS*DATA_W-1:0] regs_flat,
  input logic [IDX_W-1:0]           reg_idx,
  input logic [1:0]                 acc_mode,
  input logic                       addr_in_range,
  input logic [NUM_REGS-1:0]        wr_hit
);
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] sel_cur;
  logic [DATA_W-1:0] sel_prev_idx;
  logic              fire;

  always_ff @(posedge clk) idx_q <= reg_idx;

  assign sel_cur      = DATA_W'(regs_flat >> (reg_idx * DATA_W));
  assign sel_prev_idx = DATA_W'(regs_flat >> (idx_q * DATA_W));
  assign fire         = wr_en && addr_in_range;

  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (regs_flat == '0 && rd_data == '0));

  p_store_r2: assert property (@(posedge clk) disable iff (rst)
    (fire && acc_mode == 2'd0) |=> sel_prev_idx == $past(wr_data));

  p_set_r3: assert property (@(posedge clk) disable iff (rst)
    (fire && acc_mode == 2'd1) |=> sel_prev_idx == ($past(sel_cur) | $past(wr_data)));

  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (fire && acc_mode == 2'd2) |=> sel_prev_idx == ($past(sel_cur) & ~$past(wr_data)));

  p_invert_r5: assert property (@(posedge clk) disable iff (rst)
    (fire && acc_mode == 2'd3) |=> sel_prev_idx == ($past(sel_cur) ^ $past(wr_data)));

  p_read_value_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr_in_range) |=> rd_data == $past(sel_cur));

  p_read_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

  p_outside_write_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !addr_in_range) |=> $stable(regs_flat));

  p_outside_read_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !addr_in_range) |=> rd_data == '0);

  p_single_target_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_hit));

  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(regs_flat));

endmodule

bind alias_reg_bank alias_reg_bank_chk #(
  .DATA_W  (DATA_W),
  .NUM_REGS(NUM_REGS),
  .IDX_W   (IDX_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .rd_en        (rd_en),
  .rd_data      (rd_data),
  .regs_flat    (regs_flat),
  .reg_idx      (reg_idx),
  .acc_mode     (acc_mode),
  .addr_in_range(addr_in_range),
  .wr_hit       (wr_hit)
);

// File: tb/tb_alias_reg_bank.sv
module tb_alias_reg_bank;
  localparam int DW = 32;
  localparam int NR = 8;
  localparam int AW = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [AW-1:0]  addr = '0;
  logic           wr_en = 1'b0;
  logic [DW-1:0]  wr_data = '0;
  logic           rd_en = 1'b0;
  logic [DW-1:0]  rd_data;
  logic [NR*DW-1:0] regs_flat;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [DW-1:0] model [NR];

  always #2.5 clk = ~clk;

  alias_reg_bank #(.DATA_W(DW), .NUM_REGS(NR), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .regs_flat(regs_flat)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < NR; i++) check(req, regs_flat[i*DW +: DW], model[i]);
  endtask

  // Independent model: register number above bit 4, mode in bits 3..2.
  task automatic model_apply(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int n;
    n = int'(a) / 16;
    if (n < NR) begin
      case ((int'(a) / 4) % 4)
        0: model[n] = d;
        1: for (int b = 0; b < DW; b++) if (d[b]) model[n][b] = 1'b1;
        2: for (int b = 0; b < DW; b++) if (d[b]) model[n][b] = 1'b0;
        default: for (int b = 0; b < DW; b++) if (d[b]) model[n][b] = ~model[n][b];
      endcase
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    model_apply(a, d);
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NR; i++) model[i] = '0;
  endtask

  task automatic t_reset();
    do_reset();
    check_all("R1 reset regs");
    check("R1 reset rd_data", rd_data, '0);
  endtask

  task automatic t_store();
    logic [DW-1:0] v;
    for (int i = 0; i < NR; i++) bus_write(AW'(i*16), 32'h1111_0000 * (i + 1) ^ 32'h0F0F_5A5A);
    check_all("R2 store");
    bus_read(8'h50, v);
    check("R6 read store alias", v, model[5]);
  endtask

  task automatic t_set();
    bus_write(8'h14, 32'hF000_000F);
    check_all("R3 set");
    bus_write(8'h74, 32'h8000_0001);
    check_all("R3 set last register");
  endtask

  task automatic t_clear();
    bus_write(8'h28, 32'hFFFF_0000);
    check_all("R4 clear");
    bus_write(8'h08, 32'h0000_0000);
    check_all("R4 clear zero mask");
  endtask

  task automatic t_invert();
    bus_write(8'h3C, 32'hAAAA_5555);
    check_all("R5 invert");
    bus_write(8'h3C, 32'hAAAA_5555);
    check_all("R5 invert twice");
  endtask

  task automatic t_read_aliases();
    logic [DW-1:0] v;
    for (int m = 0; m < 4; m++) begin
      bus_read(AW'(8'h40 + m*4), v);
      check("R6 read alias", v, model[4]);
    end
    @(negedge clk);
    addr = 8'h10; wr_data = 32'hDEAD_BEEF;
    @(negedge clk);
    check("R6 hold without rd_en", rd_data, model[4]);
  endtask

  task automatic t_read_during_write();
    logic [DW-1:0] old;
    old = model[6];
    @(negedge clk);
    addr = 8'h6C; wr_data = 32'h0000_FFFF; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    model_apply(8'h6C, 32'h0000_FFFF);
    check("R7 read returns old value", rd_data, old);
    check_all("R7 write visible after edge");
  endtask

  task automatic t_out_of_range();
    logic [DW-1:0] v;
    bus_write(8'h80, 32'hFFFF_FFFF);
    bus_write(8'hF4, 32'hFFFF_FFFF);
    check_all("R8 write outside bank");
    bus_read(8'h98, v);
    check("R8 read outside bank", v, '0);
  endtask

  task automatic t_low_bits();
    bus_write(8'h25, 32'h0000_0300);
    check_all("R9 low bits 01 with set");
    bus_write(8'h5B, 32'h00FF_0000);
    check_all("R9 low bits 11 with clear");
  endtask

  task automatic t_idle();
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      addr = AW'(k * 20); wr_data = 32'h1234_5678 + k;
    end
    @(negedge clk);
    check_all("R10 idle inputs");
  endtask

  initial begin
    for (int i = 0; i < NR; i++) model[i] = '0;
    t_reset();
    t_store();
    t_set();
    t_clear();
    t_invert();
    t_read_aliases();
    t_read_during_write();
    t_out_of_range();
    t_low_bits();
    t_idle();
    t_reset();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule